// File: doc/BRIEF.md
# Capture Device Control and Status Register Block

This block is the host-visible control register file of a capture device. A single word-wide register port carries writes and combinational reads. Register index N sits at byte address 4*N, and only index 0 is implemented. A write to index 0 does two things at once. Its upper half updates a small set of level control bits under a per-bit write mask. Its lower half carries one-shot commands.

Bring-up follows a fixed order. First the host shifts a 57-bit device identifier out one bit per strobe, using only single status bits. It hunts for the sync position, reads one full lap of the identifier, and then issues one more strobe to unlock the device. Next it pulses the bus-side reset and the buffer-RAM reset and polls their completion bits. Last it walks the RAM through its enable phase, one step per command, watching a toggle bit.

The bus logic, RAM and DMA engine that would answer these handshakes are not part of this block. Fixed, parameterised latency counters stand in for them.

Top module: `capctl_regs`

## Requirements
- R1: The register index is `addr[ADDR_W-1:2]`. `addr[1:0]` are ignored. Only index 0 is decoded. Any other index reads as zero, and a write to any other index changes no state.
- R2: A read of index 0 returns this status word, with every other bit zero:
  - bit 31: unlocked.
  - bit 30: current identifier bit.
  - bit 29: sync.
  - bits 23:16: control bits.
  - bit 2: phase toggle.
  - bit 1: RAM reset done.
  - bit 0: bus reset done.

  After reset, the control bits, both done bits, the toggle and the unlocked bit are 0, and the identifier position is START_POS.
- R3: On a write to index 0, `wdata[31:24]` is a write mask for the control byte, whose new values come from `wdata[23:16]`. Each control bit takes its new value only where its mask bit is 1. The control bits are: bit 0 holds the bus reset, bit 1 holds the RAM reset, and bit 3 switches the RAM off. The other control bits are stored and have no effect.
- R4: A write to index 0 with `wdata[3]` set is a strobe. It advances the identifier position by one and wraps from 56 to 0. Status bit 30 shows bit [position] of ID_VALUE, so a full lap from position 0 reads the identifier least significant bit first.
- R5: Status bit 29 is 1 exactly when the identifier position is 0.
- R6: The device unlocks in three steps. A strobe at position 0 starts a lap. The strobe that wraps the position back to 0 completes the lap. The next strobe starts the unlock. Status bit 31 rises UNLOCK_LAT cycles after that strobe and stays set until reset. No earlier strobe sets it.
- R7: While a reset control bit is 1, its done bit is 0. The done bit sets BUS_RST_LAT (bus) or RAM_RST_LAT (RAM) cycles after the write that clears the reset control bit. It then stays set until that reset bit is set again.
- R8: A write to index 0 with `wdata[1]` set is a phase step. It is accepted when the RAM is ready and no step is pending. Ready means RAM reset done is 1, RAM reset control is 0 and RAM-off control is 0. Status bit 2 toggles STEP_LAT cycles after an accepted step.
- R9: A phase step that arrives while another is pending is ignored. So is a step while the RAM is not ready. A pending step is cancelled if the RAM stops being ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |

## Verification
The bench builds the block with these parameters:

| Parameter | Value |
|---|---|
| START_POS | 13 |
| UNLOCK_LAT | 2 |
| BUS_RST_LAT | 6 |
| RAM_RST_LAT | 9 |
| STEP_LAT | 3 |

A START_POS away from 0 makes the sync hunt take 44 strobes before the identifier lap. The two reset latencies differ, so a swapped completion path shows up. A STEP_LAT of 3 lets two back-to-back step writes land inside one pending step. It also keeps a full 128-step enable phase within a short run.

// File: rtl/capctl_pkg.sv
`timescale 1ns/1ps
package capctl_pkg;
  // status word bit positions
  localparam int ST_UNLOCKED = 31;
  localparam int ST_ID_BIT   = 30;
  localparam int ST_SYNC     = 29;
  localparam int ST_CTRL_LO  = 16;
  localparam int ST_PHASE    = 2;
  localparam int ST_RAM_DONE = 1;
  localparam int ST_BUS_DONE = 0;

  // command word fields
  localparam int CMD_MASK_LO = 24;
  localparam int CMD_VAL_LO  = 16;
  localparam int CMD_STROBE  = 3;
  localparam int CMD_STEP    = 1;

  // control byte bits
  localparam int CT_BUS_RST = 0;
  localparam int CT_RAM_RST = 1;
  localparam int CT_RAM_OFF = 3;

  localparam int N_SETTLE = 2;

  typedef enum logic [1:0] {
    SID_HUNT  = 2'd0,
    SID_LAP   = 2'd1,
    SID_ARMED = 2'd2,
    SID_OPEN  = 2'd3
  } sid_stage_e;
endpackage

// File: rtl/capctl_serial_id.sv
`timescale 1ns/1ps
module capctl_serial_id
  import capctl_pkg::*;
#(
  parameter int            IDW        = 57,
  parameter logic [IDW-1:0] ID_VALUE  = '0,
  parameter int            START_POS  = 13,
  parameter int            UNLOCK_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic id_bit,
  output logic at_sync,
  output logic unlocked
);
  localparam int PW = $clog2(IDW);
  localparam int UW = $clog2(UNLOCK_LAT + 1);

  logic [PW-1:0] pos_q;
  sid_stage_e    stage_q;
  logic          ul_busy_q;
  logic [UW-1:0] ul_cnt_q;
  logic          unl_q;
  logic          at_last;

  assign at_last  = (pos_q == PW'(IDW - 1));
  assign id_bit   = ID_VALUE[pos_q];
  assign at_sync  = (pos_q == '0);
  assign unlocked = unl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q     <= PW'(START_POS);
      stage_q   <= SID_HUNT;
      ul_busy_q <= 1'b0;
      ul_cnt_q  <= '0;
      unl_q     <= 1'b0;
    end else begin
      if (ul_busy_q) begin
        if (ul_cnt_q == UW'(1)) begin
          unl_q     <= 1'b1;
          ul_busy_q <= 1'b0;
        end else begin
          ul_cnt_q <= ul_cnt_q - UW'(1);
        end
      end
      if (strobe) begin
        pos_q <= at_last ? '0 : pos_q + PW'(1);
        case (stage_q)
          SID_HUNT:  if (at_sync) stage_q <= SID_LAP;
          SID_LAP:   if (at_last) stage_q <= SID_ARMED;
          SID_ARMED: begin
            stage_q   <= SID_OPEN;
            ul_busy_q <= 1'b1;
            ul_cnt_q  <= UW'(UNLOCK_LAT);
          end
          default: ;
        endcase
      end
    end
  end

  // R4
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q < PW'(IDW));

  // R5
  sync_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && at_sync) |=> (pos_q == PW'(1)));

  // R6
  unlock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unl_q |=> unl_q);
endmodule

// File: rtl/capctl_settle.sv
`timescale 1ns/1ps
module capctl_settle #(
  parameter int LAT = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic done
);
  localparam int CW = $clog2(LAT + 1);

  logic          armed_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign done = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else if (hold) begin
      done_q  <= 1'b0;
      armed_q <= 1'b1;
      cnt_q   <= CW'(LAT);
    end else if (armed_q) begin
      if (cnt_q == CW'(1)) begin
        done_q  <= 1'b1;
        armed_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - CW'(1);
      end
    end
  end

  // R7
  held_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !done_q);
endmodule

// File: rtl/capctl_phase_step.sv
`timescale 1ns/1ps
module capctl_phase_step #(
  parameter int STEP_LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic ready,
  output logic toggle
);
  localparam int CW = $clog2(STEP_LAT + 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic          tog_q;

  assign toggle = tog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      tog_q  <= 1'b0;
    end else if (busy_q) begin
      if (!ready) begin
        busy_q <= 1'b0;
      end else if (cnt_q == CW'(1)) begin
        tog_q  <= ~tog_q;
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - CW'(1);
      end
    end else if (step && ready) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(STEP_LAT);
    end
  end

  // R8
  no_stray_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |=> $stable(tog_q));

  // R9
  idle_when_unready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> !busy_q);
endmodule

// File: rtl/capctl_regs.sv
`timescale 1ns/1ps
module capctl_regs
  import capctl_pkg::*;
#(
  parameter int             ADDR_W      = 8,
  parameter int             IDW         = 57,
  parameter logic [IDW-1:0] ID_VALUE    = 57'h1_A5C3_E97B_24D1_86,
  parameter int             START_POS   = 13,
  parameter int             UNLOCK_LAT  = 2,
  parameter int             BUS_RST_LAT = 6,
  parameter int             RAM_RST_LAT = 9,
  parameter int             STEP_LAT    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] reg_idx;
  logic             sel0;
  logic             wr0;
  logic [7:0]       ctrl_q;
  logic [7:0]       cmd_mask;
  logic [7:0]       cmd_val;
  logic [N_SETTLE-1:0] settle_hold;
  logic [N_SETTLE-1:0] settle_done;
  logic             id_bit, at_sync, unlocked;
  logic             ram_ready;
  logic             phase_tog;
  logic [31:0]      status;
  logic             unused_bits;

  assign reg_idx  = addr[ADDR_W-1:2];
  assign sel0     = (reg_idx == '0);
  assign wr0      = wr_en && sel0;
  assign cmd_mask = wdata[CMD_MASK_LO +: 8];
  assign cmd_val  = wdata[CMD_VAL_LO +: 8];
  assign unused_bits = ^{wdata[15:4], wdata[2], wdata[0], addr[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr0) ctrl_q <= (ctrl_q & ~cmd_mask) | (cmd_val & cmd_mask);
  end

  capctl_serial_id #(
    .IDW(IDW), .ID_VALUE(ID_VALUE),
    .START_POS(START_POS), .UNLOCK_LAT(UNLOCK_LAT)
  ) u_sid (
    .clk(clk), .rst_n(rst_n),
    .strobe(wr0 && wdata[CMD_STROBE]),
    .id_bit(id_bit), .at_sync(at_sync), .unlocked(unlocked)
  );

  assign settle_hold[0] = ctrl_q[CT_BUS_RST];
  assign settle_hold[1] = ctrl_q[CT_RAM_RST];

  for (genvar g = 0; g < N_SETTLE; g++) begin : g_settle
    localparam int LAT_G = (g == 0) ? BUS_RST_LAT : RAM_RST_LAT;
    capctl_settle #(.LAT(LAT_G)) u_settle (
      .clk(clk), .rst_n(rst_n),
      .hold(settle_hold[g]), .done(settle_done[g])
    );
  end

  assign ram_ready = settle_done[1] && !ctrl_q[CT_RAM_RST] && !ctrl_q[CT_RAM_OFF];

  capctl_phase_step #(.STEP_LAT(STEP_LAT)) u_phase (
    .clk(clk), .rst_n(rst_n),
    .step(wr0 && wdata[CMD_STEP]),
    .ready(ram_ready),
    .toggle(phase_tog)
  );

  always_comb begin
    status = '0;
    status[ST_UNLOCKED]      = unlocked;
    status[ST_ID_BIT]        = id_bit;
    status[ST_SYNC]          = at_sync;
    status[ST_CTRL_LO +: 8]  = ctrl_q;
    status[ST_PHASE]         = phase_tog;
    status[ST_RAM_DONE]      = settle_done[1];
    status[ST_BUS_DONE]      = settle_done[0];
  end

  assign rdata = sel0 ? status : 32'h0;

  // R1
  regsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sel0) |=> $stable(ctrl_q));

  // R3
  unmasked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0 && cmd_mask == 8'h00) |=> $stable(ctrl_q));
endmodule

// File: tb/tb_capctl_regs.sv
`timescale 1ns/1ps
module tb_capctl_regs;
  localparam int AW = 8;
  localparam int IDW = 57;
  localparam logic [IDW-1:0] IDV = 57'h1_A5C3_E97B_24D1_86;
  localparam int START = 13;
  localparam int UL = 2;
  localparam int BL = 6;
  localparam int RL = 9;
  localparam int SL = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  capctl_regs #(
    .ADDR_W(AW), .IDW(IDW), .ID_VALUE(IDV), .START_POS(START),
    .UNLOCK_LAT(UL), .BUS_RST_LAT(BL), .RAM_RST_LAT(RL), .STEP_LAT(SL)
  ) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  // behavioural reference model
  int       m_pos, m_stage, m_ucnt, m_bcnt, m_rcnt, m_scnt;
  bit       m_unl, m_busdone, m_ramdone, m_tog;
  bit [7:0] m_ctrl;

  task automatic m_init();
    m_pos = START; m_stage = 0; m_ucnt = 0; m_bcnt = 0; m_rcnt = 0; m_scnt = 0;
    m_unl = 0; m_busdone = 0; m_ramdone = 0; m_tog = 0; m_ctrl = '0;
  endtask

  task automatic m_tick();
    bit       w0;
    bit [7:0] oc;
    bit       rdy;
    w0  = wr_en && (addr[AW-1:2] == '0);
    oc  = m_ctrl;
    rdy = m_ramdone && !oc[1] && !oc[3];
    if (m_ucnt > 0) begin
      if (m_ucnt == 1) m_unl = 1;
      m_ucnt--;
    end
    if (w0 && wdata[3]) begin
      if (m_stage == 0 && m_pos == 0) m_stage = 1;
      else if (m_stage == 1 && m_pos == IDW - 1) m_stage = 2;
      else if (m_stage == 2) begin m_stage = 3; m_ucnt = UL; end
      m_pos = (m_pos + 1) % IDW;
    end
    if (oc[0]) begin m_busdone = 0; m_bcnt = BL; end
    else if (m_bcnt > 0) begin if (m_bcnt == 1) m_busdone = 1; m_bcnt--; end
    if (oc[1]) begin m_ramdone = 0; m_rcnt = RL; end
    else if (m_rcnt > 0) begin if (m_rcnt == 1) m_ramdone = 1; m_rcnt--; end
    if (m_scnt > 0) begin
      if (!rdy) m_scnt = 0;
      else if (m_scnt == 1) begin m_tog = !m_tog; m_scnt = 0; end
      else m_scnt--;
    end else if (w0 && wdata[1] && rdy) m_scnt = SL;
    if (w0) m_ctrl = (oc & ~wdata[31:24]) | (wdata[23:16] & wdata[31:24]);
  endtask

  function automatic logic [31:0] m_status(input logic [AW-1:0] a);
    logic [31:0] s;
    s = '0;
    if (a[AW-1:2] != '0) return s;
    s[31] = m_unl; s[30] = IDV[m_pos]; s[29] = (m_pos == 0);
    s[23:16] = m_ctrl; s[2] = m_tog; s[1] = m_ramdone; s[0] = m_busdone;
    return s;
  endfunction

  initial m_init();
  always @(posedge clk) begin
    if (!rst_n) m_init();
    else m_tick();
  end

  always @(posedge clk) begin
    #1;
    if (rst_n && !finished) begin
      vectors++;
      if (rdata !== m_status(addr)) begin
        miscompares++;
        $display("FAIL R2 per-cycle model: got %h expected %h (addr %h)", rdata, m_status(addr), addr);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0; addr = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0]    v;
    logic [IDW-1:0] got_id;
    int             n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    rd(0, v); check("R2 reset status", v, 32'(IDV[START]) << 30);

    // R1 decoding
    rd(8'h04, v); check("R1 other index reads zero", v, 32'h0);
    wr(8'h08, 32'h0101_0000);
    rd(0, v); check("R1 write to index 2 ignored", {24'h0, v[23:16]}, 32'h0);
    wr(8'h01, 32'h8080_0000);
    rd(0, v); check("R1 low address bits ignored", {24'h0, v[23:16]}, 32'h80);
    wr(0, 32'h8000_0000);

    // R3 masking
    wr(0, 32'h00FF_0000);
    rd(0, v); check("R3 zero mask no change", {24'h0, v[23:16]}, 32'h0);
    wr(0, 32'h10FF_0000);
    rd(0, v); check("R3 single masked bit", {24'h0, v[23:16]}, 32'h10);
    wr(0, 32'h1000_0000);

    // R7 bus reset handshake
    wr(0, 32'h0101_0000);
    rd(0, v); check("R7 bus done low while held", {31'h0, v[0]}, 32'h0);
    wr(0, 32'h0100_0000);
    repeat (BL - 1) @(negedge clk);
    rd(0, v); check("R7 bus done not early", {31'h0, v[0]}, 32'h0);
    @(negedge clk);
    rd(0, v); check("R7 bus done at latency", {31'h0, v[0]}, 32'h1);

    // R7 RAM reset handshake
    wr(0, 32'h0202_0000);
    rd(0, v); check("R7 ram done low while held", {31'h0, v[1]}, 32'h0);
    wr(0, 32'h0200_0000);
    repeat (RL - 1) @(negedge clk);
    rd(0, v); check("R7 ram done not early", {31'h0, v[1]}, 32'h0);
    @(negedge clk);
    rd(0, v); check("R7 ram done at latency", {31'h0, v[1]}, 32'h1);

    // R5 sync hunt
    n = 0;
    rd(0, v);
    while (!v[29] && n < 100) begin
      wr(0, 32'h8);
      n++;
      rd(0, v);
    end
    check("R5 strobes to sync", 32'(n), 32'(IDW - START));

    // R4 identifier lap
    got_id = '0;
    for (int i = 0; i < IDW; i++) begin
      rd(0, v);
      got_id[i] = v[30];
      wr(0, 32'h8);
      if (i == 0) begin
        rd(0, v); check("R5 sync drops after strobe", {31'h0, v[29]}, 32'h0);
      end
    end
    check("R4 identifier low word", got_id[31:0], IDV[31:0]);
    check("R4 identifier high part", 32'(got_id[IDW-1:32]), 32'(IDV[IDW-1:32]));
    rd(0, v);
    check("R6 still locked after lap", {30'h0, v[31], v[29]}, 32'h1);

    // R6 unlock strobe
    wr(0, 32'h8);
    repeat (UL - 1) @(negedge clk);
    rd(0, v); check("R6 unlock not early", {31'h0, v[31]}, 32'h0);
    @(negedge clk);
    rd(0, v); check("R6 unlock at latency", {31'h0, v[31]}, 32'h1);
    wr(0, 32'h8);
    wr(0, 32'h8);
    rd(0, v); check("R6 unlock stays", {31'h0, v[31]}, 32'h1);

    // R8 single step
    wr(0, 32'h2);
    repeat (SL - 1) @(negedge clk);
    rd(0, v); check("R8 toggle not early", {31'h0, v[2]}, 32'h0);
    @(negedge clk);
    rd(0, v); check("R8 toggle at latency", {31'h0, v[2]}, 32'h1);

    // R8 full enable phase of 128 steps
    for (int k = 0; k < 128; k++) begin
      wr(0, 32'h2);
      repeat (SL + 1) @(negedge clk);
    end
    rd(0, v); check("R8 parity after 128 steps", {31'h0, v[2]}, 32'h1);

    // R9 step while pending
    wr(0, 32'h2);
    wr(0, 32'h2);
    repeat (SL + 4) @(negedge clk);
    rd(0, v); check("R9 second step ignored", {31'h0, v[2]}, 32'h0);

    // R9 RAM switched off
    wr(0, 32'h0B0B_0000);
    rd(0, v); check("R3 disable sets three bits", {24'h0, v[23:16]}, 32'h0B);
    wr(0, 32'h0300_0000);
    repeat (RL + 2) @(negedge clk);
    rd(0, v); check("R7 done after disable release", {24'h0, v[23:16]} | {30'h0, v[1:0]}, 32'h0B);
    wr(0, 32'h2);
    repeat (SL + 3) @(negedge clk);
    rd(0, v); check("R9 step ignored while off", {31'h0, v[2]}, 32'h0);
    wr(0, 32'h0800_0000);
    wr(0, 32'h2);
    repeat (SL + 1) @(negedge clk);
    rd(0, v); check("R8 step after re-enable", {31'h0, v[2]}, 32'h1);

    // R9 step cancelled by RAM reset
    wr(0, 32'h2);
    wr(0, 32'h0202_0000);
    repeat (SL + 3) @(negedge clk);
    rd(0, v); check("R9 pending step cancelled", {31'h0, v[2]}, 32'h1);
    wr(0, 32'h0200_0000);
    repeat (RL + 1) @(negedge clk);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule